// File: doc/BRIEF.md
# GF(2^8) Byte-Lane Multiply and Affine-Inverse Unit

This unit works on a vector of bytes, each byte treated as an element of the finite field GF(2^8) under the fixed reduction x^8 = x^4 + x^3 + x + 1. It has three operations. Multiply forms the carry-less product of two bytes in each lane and reduces it. Affine passes each byte through a bit-matrix transform and then XORs in an 8-bit constant. Inverse-affine first replaces each byte with its field inverse and then applies the same matrix transform and constant.

A single 64-bit matrix word is shared by each group of eight consecutive byte lanes. The 8-bit constant is common to all lanes. A request is accepted in any cycle where `in_valid` is high. Its result appears two clock edges later and is marked by `out_valid`. The pipeline never stalls, so requests can be issued back to back. With an identity matrix and a zero constant, the inverse-affine operation gives a pure field inverse. With the well-known substitution matrix and constant 0x63, it gives a byte substitution box.

Top module: `gf8_affine_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high, two rising edges later. Consecutive requests produce results in consecutive cycles.
- R3: With `in_op` = 0 (multiply), each output lane is the carry-less product of the `in_a` and `in_b` lanes, reduced modulo 0x11b. For example, 0x57*0x83 = 0xC1 and 0x53*0xCA = 0x01.
- R4: With `in_op` = 1 (affine), output bit j of a lane equals the XOR of the input bits selected by mask byte 7-j of the lane's matrix word, which is bits [(7-j)*8+7 : (7-j)*8]. That result is then XORed with `in_imm[j]`. The identity matrix is 0x0102040810204080 and the bit-reversal matrix is 0x8040201008040201.
- R5: Lane l (bits [l*8+7 : l*8]) uses the matrix word of group g = l/8, located at `in_mat[g*64+63 : g*64]`.
- R6: With `in_op` = 2 (inverse-affine), each lane is first inverted in the field and then transformed as in R4. The identity matrix with constant 0 gives x*y = 1 for every nonzero x. The matrix 0xF1E3C78F1F3E7CF8 with constant 0x63 maps 0x00, 0x01 and 0x53 to 0x63, 0x7C and 0xED.
- R7: The field inverse of 0x00 is taken as 0x00, so inverse-affine of a zero byte yields the constant.
- R8: With `in_op` = 3 (reserved), every output lane is 0x00.
- R9: Multiply ignores `in_mat` and `in_imm`. Affine and inverse-affine ignore `in_b`.
- R10: When `out_valid` is low, `out_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 0 multiply, 1 affine, 2 inverse-affine, 3 reserved |
| in_a | input | LANES*8 | Byte-lane operand A |
| in_b | input | LANES*8 | Byte-lane operand B (multiply only) |
| in_mat | input | (LANES/8)*64 | One 64-bit matrix word per group of eight lanes |
| in_imm | input | 8 | Constant XORed after the matrix transform |
| out_valid | output | 1 | Result strobe, two edges after the request |
| out_data | output | LANES*8 | Result byte lanes |

## Verification
Multiply is tried with the textbook field products, with zero and one operands, and with per-lane pseudo-random byte pairs. The random pairs separate reduction-constant errors from lane-indexing errors. Every byte value is passed through inverse-affine with the identity matrix, and each result is checked by multiplying it back to one. The substitution-box matrix and the bit-reversal matrix tell the mask-byte ordering apart from its mirror image, and they also catch a swapped inverse/transform order. Putting a different matrix in each group, changing ignored operands, and issuing back-to-back requests separate the group mapping, operand gating and pipeline timing.

// File: rtl/gf8_pkg.sv
package gf8_pkg;

    // Low byte of the field polynomial x^8 + x^4 + x^3 + x + 1
    localparam logic [7:0] GF8_RED = 8'h1b;

    typedef enum logic [1:0] {
        OP_MUL    = 2'd0,
        OP_AFF    = 2'd1,
        OP_INVAFF = 2'd2,
        OP_RSVD   = 2'd3
    } gf8_op_e;

    typedef struct packed {
        logic       valid;
        gf8_op_e    op;
        logic [7:0] imm;
    } gf8_ctl_t;

    // Full 15-bit carry-less product of two bytes
    function automatic logic [14:0] gf8_clmul(input logic [7:0] a, input logic [7:0] b);
        logic [14:0] acc;
        acc = '0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ (15'(a) << i);
        end
        return acc;
    endfunction

    // Fold the high terms back, highest degree first
    function automatic logic [7:0] gf8_reduce(input logic [14:0] p);
        logic [14:0] r;
        r = p;
        for (int k = 14; k >= 8; k--) begin
            if (r[k]) r = r ^ ({6'd0, 1'b1, GF8_RED} << (k - 8));
        end
        return r[7:0];
    endfunction

    function automatic logic [7:0] gf8_mul(input logic [7:0] a, input logic [7:0] b);
        return gf8_reduce(gf8_clmul(a, b));
    endfunction

    // x^254 by a square-and-multiply chain; zero maps to zero
    function automatic logic [7:0] gf8_inv(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] acc;
        sq  = gf8_mul(x, x);
        acc = sq;
        for (int i = 2; i < 8; i++) begin
            sq  = gf8_mul(sq, sq);
            acc = gf8_mul(acc, sq);
        end
        return acc;
    endfunction

    // Output bit j is the parity of x under mask byte (7-j) of the word
    function automatic logic [7:0] gf8_matrix(input logic [63:0] m, input logic [7:0] x);
        logic [7:0] y;
        for (int j = 0; j < 8; j++) begin
            y[j] = ^(m[(7 - j) * 8 +: 8] & x);
        end
        return y;
    endfunction

endpackage

// File: rtl/gf8_lane_pre.sv
// First half of a lane: field multiply, field inverse or pass-through.
module gf8_lane_pre
    import gf8_pkg::*;
(
    input  gf8_op_e    op,
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] y
);
    always_comb begin
        unique case (op)
            OP_MUL:    y = gf8_mul(a, b);
            OP_AFF:    y = a;
            OP_INVAFF: y = gf8_inv(a);
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/gf8_lane_post.sv
// Second half of a lane: matrix transform plus constant, or pass-through.
module gf8_lane_post
    import gf8_pkg::*;
(
    input  gf8_op_e     op,
    input  logic [63:0] mat,
    input  logic [7:0]  imm,
    input  logic [7:0]  x,
    output logic [7:0]  y
);
    always_comb begin
        unique case (op)
            OP_MUL:            y = x;
            OP_AFF, OP_INVAFF: y = gf8_matrix(mat, x) ^ imm;
            default:           y = '0;
        endcase
    end
endmodule

// File: rtl/gf8_affine_unit.sv
module gf8_affine_unit
    import gf8_pkg::*;
#(
    parameter int LANES = 16   // must be a multiple of 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [1:0]                in_op,
    input  logic [LANES*8-1:0]        in_a,
    input  logic [LANES*8-1:0]        in_b,
    input  logic [(LANES/8)*64-1:0]   in_mat,
    input  logic [7:0]                in_imm,
    output logic                      out_valid,
    output logic [LANES*8-1:0]        out_data
);
    localparam int GROUPS = LANES / 8;
    localparam int DW     = LANES * 8;
    localparam int MW     = GROUPS * 64;

    gf8_op_e   in_opc;
    gf8_ctl_t  ctl_q;
    logic [DW-1:0] pre_d;
    logic [DW-1:0] pre_q;
    logic [DW-1:0] post_d;
    logic [MW-1:0] mat_q;

    assign in_opc = gf8_op_e'(in_op);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        gf8_lane_pre u_pre (
            .op (in_opc),
            .a  (in_a[l*8 +: 8]),
            .b  (in_b[l*8 +: 8]),
            .y  (pre_d[l*8 +: 8])
        );
        gf8_lane_post u_post (
            .op  (ctl_q.op),
            .mat (mat_q[(l/8)*64 +: 64]),
            .imm (ctl_q.imm),
            .x   (pre_q[l*8 +: 8]),
            .y   (post_d[l*8 +: 8])
        );
    end

    // Stage 1: multiply / inverse result and the operands for stage 2
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            pre_q <= '0;
            mat_q <= '0;
        end else begin
            ctl_q.valid <= in_valid;
            if (in_valid) begin
                ctl_q.op  <= in_opc;
                ctl_q.imm <= in_imm;
                pre_q     <= pre_d;
                mat_q     <= in_mat;
            end
        end
    end

    // Stage 2: matrix transform, constant, output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl_q.valid;
            if (ctl_q.valid) out_data <= post_d;
        end
    end
endmodule

// File: rtl/gf8_affine_chk.sv
module gf8_affine_chk
    import gf8_pkg::*;
#(
    parameter int LANES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [1:0]         in_op,
    input logic [7:0]         a0,
    input logic [7:0]         b0,
    input logic [7:0]         in_imm,
    input logic               out_valid,
    input logic [LANES*8-1:0] out_data
);
    logic       v1, v2;
    logic [1:0] op1, op2;
    logic [7:0] a1, a2, b1, b2, imm1, imm2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; v2 <= 1'b0;
            op1 <= '0; op2 <= '0;
            a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0;
            imm1 <= '0; imm2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1;
            op1 <= in_op;   op2 <= op1;
            a1 <= a0;       a2 <= a1;
            b1 <= b0;       b2 <= b1;
            imm1 <= in_imm; imm2 <= imm1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == v2);

    a_r3_mul_lane0: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op2 == 2'd0) |-> out_data[7:0] == gf8_mul(a2, b2));

    a_r7_inv_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op2 == 2'd2 && a2 == 8'h00) |-> out_data[7:0] == imm2);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op2 == 2'd3) |-> out_data == '0);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));
endmodule

bind gf8_affine_unit gf8_affine_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .a0        (in_a[7:0]),
    .b0        (in_b[7:0]),
    .in_imm    (in_imm),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_gf8_affine_unit.sv
module tb_gf8_affine_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 16;
    localparam int GROUPS = LANES / 8;
    localparam int DW     = LANES * 8;
    localparam int MW     = GROUPS * 64;

    localparam logic [63:0] M_ID  = 64'h0102040810204080;
    localparam logic [63:0] M_REV = 64'h8040201008040201;
    localparam logic [63:0] M_SUB = 64'hF1E3C78F1F3E7CF8;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [63:0] mat;
        logic [7:0]  imm;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h57, 8'h83, 64'h0,  8'h00, 8'hC1},  // R3
        '{2'd0, 8'h57, 8'h13, 64'h0,  8'h00, 8'hFE},  // R3
        '{2'd0, 8'h53, 8'hCA, 64'h0,  8'h00, 8'h01},  // R3
        '{2'd0, 8'h00, 8'hFF, 64'h0,  8'h00, 8'h00},  // R3
        '{2'd0, 8'h01, 8'hA5, 64'h0,  8'h00, 8'hA5},  // R3
        '{2'd0, 8'h80, 8'h02, M_SUB,  8'h5A, 8'h1B},  // R3 R9 mat/imm ignored
        '{2'd1, 8'h3C, 8'h99, M_ID,   8'h00, 8'h3C},  // R4
        '{2'd1, 8'h3C, 8'h00, M_ID,   8'h5A, 8'h66},  // R4
        '{2'd1, 8'hE7, 8'h00, 64'h0,  8'h77, 8'h77},  // R4
        '{2'd1, 8'h01, 8'h00, M_REV,  8'h00, 8'h80},  // R4 bit order
        '{2'd1, 8'hCA, 8'h00, M_SUB,  8'h63, 8'hED},  // R4
        '{2'd2, 8'h53, 8'h00, M_ID,   8'h00, 8'hCA},  // R6
        '{2'd2, 8'h01, 8'h00, M_ID,   8'h00, 8'h01},  // R6
        '{2'd2, 8'h53, 8'h00, M_SUB,  8'h63, 8'hED},  // R6
        '{2'd2, 8'h01, 8'h00, M_SUB,  8'h63, 8'h7C},  // R6
        '{2'd2, 8'h00, 8'h00, M_SUB,  8'h63, 8'h63},  // R7
        '{2'd3, 8'h53, 8'hCA, M_ID,   8'h5A, 8'h00}   // R8
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    in_op;
    logic [DW-1:0] in_a, in_b;
    logic [MW-1:0] in_mat;
    logic [7:0]    in_imm;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gf8_affine_unit #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_mat(in_mat), .in_imm(in_imm),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Bit-serial reference multiply: shift A, fold 0x1b on overflow
    function automatic logic [7:0] bm_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] x, y, p;
        x = a; y = b; p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (y[0]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] bm_aff(input logic [63:0] m, input logic [7:0] x);
        logic [7:0] y;
        logic [7:0] mask;
        for (int j = 0; j < 8; j++) begin
            mask = m[63 - 8*j -: 8];
            y[j] = 1'b0;
            for (int k = 0; k < 8; k++) y[j] = y[j] ^ (mask[k] & x[k]);
        end
        return y;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Drive at a falling edge; result is visible two falling edges later
    task automatic run(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [MW-1:0] m, input logic [7:0] imm);
        in_op = op; in_a = a; in_b = b; in_mat = m; in_imm = imm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] a, b, e, held;
        logic [7:0]    x, y;
        logic [31:0]   seed;

        rst = 1'b1; in_valid = 1'b0; in_op = '0;
        in_a = '0; in_b = '0; in_mat = '0; in_imm = '0;
        repeat (3) @(negedge clk);
        check_bit("R1 valid in reset", out_valid, 1'b0);
        check("R1 data in reset", out_data, '0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 valid after reset", out_valid, 1'b0);
        check("R1 data after reset", out_data, '0);

        // Table walk, byte broadcast to all lanes
        for (int i = 0; i < NV; i++) begin
            run(VECS[i].op, {LANES{VECS[i].a}}, {LANES{VECS[i].b}},
                {GROUPS{VECS[i].mat}}, VECS[i].imm);
            check_bit($sformatf("R2 valid vec %0d", i), out_valid, 1'b1);
            check($sformatf("table vec %0d", i), out_data, {LANES{VECS[i].exp}});
        end

        // R2: exact latency
        in_op = 2'd0; in_a = {LANES{8'h02}}; in_b = {LANES{8'h03}};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R2 not after one edge", out_valid, 1'b0);
        @(negedge clk);
        check_bit("R2 valid after two edges", out_valid, 1'b1);
        check("R2 data", out_data, {LANES{8'h06}});
        @(negedge clk);
        check_bit("R2 single pulse", out_valid, 1'b0);

        // R2: back-to-back requests
        in_op = 2'd0; in_a = {LANES{8'h57}}; in_b = {LANES{8'h83}}; in_valid = 1'b1;
        @(negedge clk);
        in_op = 2'd1; in_a = {LANES{8'h3C}}; in_mat = {GROUPS{M_REV}}; in_imm = 8'h00;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R2 b2b first valid", out_valid, 1'b1);
        check("R2 b2b first", out_data, {LANES{8'hC1}});
        @(negedge clk);
        check_bit("R2 b2b second valid", out_valid, 1'b1);
        check("R2 b2b second", out_data, {LANES{8'h3C}});

        // R5: a different matrix per group
        run(2'd1, {LANES{8'h01}}, '0, {M_REV, M_ID}, 8'h00);
        check("R5 group matrices", out_data, {{8{8'h80}}, {8{8'h01}}});
        run(2'd2, {LANES{8'h53}}, '0, {M_ID, M_SUB}, 8'h00);
        check("R5 group matrices inverse", out_data, {{8{8'hCA}}, {8{8'hED ^ 8'h63}}});

        // R3 and R4: pseudo-random distinct lanes
        seed = 32'h1234_5677;
        for (int t = 0; t < 8; t++) begin
            for (int l = 0; l < DW; l += 32) begin
                seed = seed * 32'd1664525 + 32'd1013904223; a[l +: 32] = seed;
                seed = seed * 32'd1664525 + 32'd1013904223; b[l +: 32] = seed;
            end
            for (int l = 0; l < LANES; l++) e[l*8 +: 8] = bm_mul(a[l*8 +: 8], b[l*8 +: 8]);
            run(2'd0, a, b, {GROUPS{64'h0}}, 8'h00);
            check($sformatf("R3 random mul %0d", t), out_data, e);
            for (int l = 0; l < LANES; l++)
                e[l*8 +: 8] = bm_aff({b[63:0]}, a[l*8 +: 8]) ^ 8'hA6;
            run(2'd1, a, '0, {GROUPS{b[63:0]}}, 8'hA6);
            check($sformatf("R4 random affine %0d", t), out_data, e);
        end

        // R9: in_b ignored by affine ops
        run(2'd1, {LANES{8'h3C}}, {LANES{8'hFF}}, {GROUPS{M_SUB}}, 8'h11);
        e = out_data;
        run(2'd1, {LANES{8'h3C}}, {LANES{8'h5A}}, {GROUPS{M_SUB}}, 8'h11);
        check("R9 b ignored affine", out_data, e);
        run(2'd2, {LANES{8'h77}}, {LANES{8'h12}}, {GROUPS{M_ID}}, 8'h00);
        e = out_data;
        run(2'd2, {LANES{8'h77}}, {LANES{8'hED}}, {GROUPS{M_ID}}, 8'h00);
        check("R9 b ignored inverse", out_data, e);

        // R6 and R7: exhaustive inverse
        for (int t = 0; t < 256 / LANES; t++) begin
            for (int l = 0; l < LANES; l++) a[l*8 +: 8] = 8'(t * LANES + l);
            run(2'd2, a, '0, {GROUPS{M_ID}}, 8'h00);
            for (int l = 0; l < LANES; l++) begin
                x = a[l*8 +: 8];
                y = out_data[l*8 +: 8];
                n_vec++;
                if (x == 8'h00) begin
                    if (y !== 8'h00) begin
                        n_fail++;
                        $display("FAIL R7 inv(0): got %h expected 00", y);
                    end
                end else if (bm_mul(x, y) !== 8'h01) begin
                    n_fail++;
                    $display("FAIL R6 inv(%h): got product %h expected 01", x, bm_mul(x, y));
                end
            end
        end

        // R10: output held while idle
        run(2'd0, {LANES{8'h53}}, {LANES{8'hCA}}, '0, 8'h00);
        held = out_data;
        in_op = 2'd1; in_a = {LANES{8'hFF}}; in_mat = {GROUPS{M_SUB}}; in_imm = 8'h42;
        repeat (3) @(negedge clk);
        check_bit("R10 idle valid", out_valid, 1'b0);
        check("R10 data held", out_data, held);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule